// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock for an SD/MMC host from the master clock. One control register selects the divide ratio, switches the card clock on and off, and can hold the clock quiet while the host reports an idle bus. The ratio field is mostly one-hot. Each bit picks a power-of-two ratio. Further encodings give the undivided master clock, divide-by-2 and, when a build parameter allows it, divide-by-1024.

Software works out the ratio for a target frequency and writes it. The block then produces two outputs. The first is a level card clock. The second is a one-cycle strobe that marks the start of each card clock period, so logic in the master domain can advance in step with the card. A high phase on the card clock is never cut short. Stopping waits for the current high phase to finish. A ratio written while the clock runs waits for the next period boundary.

Top module: `sdclk_divider`

## Requirements
- R1: After reset, `sdClk` and `sdClkEn` are low and no card clock runs until the enable bit is written.
- R2: Bits [7:0] of the control word are the ratio field. Bit i selects a ratio of 2^(i+2). With bits [7:0], 10 and 16 all clear, the ratio is 2. For a ratio N of 2 or more, `sdClk` is high for N/2 master cycles and then low for N/2. `sdClkEn` is high for exactly the first cycle of each high phase, so the strobe period is N. A ratio written while the clock is stopped is used from the next enable.
- R3: Bit 10 selects the undivided master clock and overrides every other ratio bit. `sdClk` then follows the master clock and `sdClkEn` is high on every running cycle.
- R4: Bit 16 selects a ratio of 1024 when `HAS_DIV1024` is 1. When `HAS_DIV1024` is 0, the same bit selects 512.
- R5: When several bits of [7:0] are set, the lowest set bit decides the ratio. Any set bit in [7:0] also overrides bit 16.
- R6: Bit 8 enables the card clock. A write that enables it restarts the period counter from zero. The first high phase begins on the second master edge after the edge that accepts the write, with `sdClkEn` high in that cycle, and it is a full-length high phase.
- R7: When bit 8 is cleared during a high phase, that high phase finishes at full length and `sdClk` then stays low. When it is cleared during a low phase, the clock stops at once. No `sdClkEn` pulse occurs while the clock is stopped.
- R8: When bit 9 is set and `busIdle` is high, the clock stops in the same way as R7. It restarts from zero when `busIdle` falls. When bit 9 is clear, `busIdle` has no effect.
- R9: A ratio written while the clock runs does not shorten the period in progress. The new ratio starts at the next period boundary, which is the end of a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write strobe for the control word |
| cfgWrData | input | 32 | Control word: ratio bits [7:0], enable 8, idle stop 9, undivided 10, slowest ratio 16 |
| busIdle | input | 1 | High while the card bus carries no traffic |
| sdClkEn | output | 1 | One-cycle strobe at the start of each card clock period |
| sdClk | output | 1 | Gated card clock |

## Verification
A wrong count or a wrong ratio register shows up as a high phase of the wrong length. It also shows as a wrong gap between `sdClkEn` strobes, within one card period of the fault. A stale pending ratio is caught by the first period after a boundary, which has the wrong length. A bad stop decision shows up during the stopped window that follows a disable or an idle request, as an extra or clipped high phase on `sdClk`. Every high phase is compared against the width the requirements predict for the ratio and mode in force when it began.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  // control word layout
  localparam int REG_W       = 32;
  localparam int DIV_BITS    = 8;
  localparam int POS_DIV0    = 0;
  localparam int POS_EN      = 8;
  localparam int POS_IDLESTP = 9;
  localparam int POS_UNDIV   = 10;
  localparam int POS_SLOWEST = 16;

  // ratio carried as log2 of the divide value
  localparam int MAX_SHIFT = 10;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int CNT_W     = MAX_SHIFT;
  localparam int FIRST_SH  = 2;

  localparam logic [SHIFT_W-1:0] SH_UNDIV = SHIFT_W'(0);
  localparam logic [SHIFT_W-1:0] SH_HALF  = SHIFT_W'(1);

  typedef struct packed {
    logic               wantRun;
    logic [SHIFT_W-1:0] shift;
  } ctrl_stb_t;
endpackage

// File: rtl/sdclk_div_ctrl.sv
module sdclk_div_ctrl
  import sdclk_pkg::*;
#(
  parameter bit HAS_DIV1024 = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             busIdle,
  output ctrl_stb_t        stb
);
  logic                enQ, idleStopQ, undivQ, slowestQ;
  logic [DIV_BITS-1:0] divQ;
  logic [SHIFT_W-1:0]  slowestSh;
  logic [SHIFT_W-1:0]  pendShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ       <= 1'b0;
      idleStopQ <= 1'b0;
      undivQ    <= 1'b0;
      slowestQ  <= 1'b0;
      divQ      <= '0;
    end else if (cfgWrEn) begin
      enQ       <= cfgWrData[POS_EN];
      idleStopQ <= cfgWrData[POS_IDLESTP];
      undivQ    <= cfgWrData[POS_UNDIV];
      slowestQ  <= cfgWrData[POS_SLOWEST];
      divQ      <= cfgWrData[POS_DIV0 +: DIV_BITS];
    end
  end

  // slowest ratio depends on the build capability
  generate
    if (HAS_DIV1024) begin : gSlow1024
      assign slowestSh = SHIFT_W'(MAX_SHIFT);
    end else begin : gSlow512
      assign slowestSh = SHIFT_W'(MAX_SHIFT - 1);
    end
  endgenerate

  // undivided beats all; lowest one-hot bit beats higher ones and the slowest bit
  always_comb begin
    logic               found;
    logic [SHIFT_W-1:0] lowSh;
    found = 1'b0;
    lowSh = SH_HALF;
    for (int i = DIV_BITS - 1; i >= 0; i--) begin
      if (divQ[i]) begin
        found = 1'b1;
        lowSh = SHIFT_W'(i + FIRST_SH);
      end
    end
    if (undivQ)        pendShift = SH_UNDIV;
    else if (found)    pendShift = lowSh;
    else if (slowestQ) pendShift = slowestSh;
    else               pendShift = SH_HALF;
  end

  assign stb.wantRun = enQ & ~(idleStopQ & busIdle);
  assign stb.shift   = pendShift;
endmodule

// File: rtl/sdclk_div_dp.sv
module sdclk_div_dp
  import sdclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_stb_t          stb,
  output logic               sdClk,
  output logic               sdClkEn,
  output logic               runQ,
  output logic               slowQ,
  output logic               fastQ,
  output logic               boundary,
  output logic [SHIFT_W-1:0] curShiftQ
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ, cntInc, halfCnt, lastCnt;
  logic             lastHigh, stopNow, nextFast, gateQ;

  assign cntInc   = cntQ + CNT_ONE;
  assign halfCnt  = CNT_ONE << (curShiftQ - SH_HALF);
  assign lastCnt  = (CNT_ONE << curShiftQ) - CNT_ONE;
  assign lastHigh = (cntQ == halfCnt - CNT_ONE);
  assign boundary = runQ & (fastQ | (cntQ == lastCnt));
  assign nextFast = (stb.shift == SH_UNDIV);
  // stop only where no high phase gets clipped
  assign stopNow  = runQ & ~stb.wantRun & (fastQ | ~slowQ | lastHigh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      slowQ     <= 1'b0;
      fastQ     <= 1'b0;
      cntQ      <= '0;
      curShiftQ <= SH_HALF;
    end else if (!runQ) begin
      curShiftQ <= stb.shift;
      fastQ     <= nextFast;
      cntQ      <= '0;
      runQ      <= stb.wantRun;
      slowQ     <= stb.wantRun & ~nextFast;
    end else if (stopNow) begin
      runQ  <= 1'b0;
      slowQ <= 1'b0;
      cntQ  <= '0;
    end else if (boundary) begin
      curShiftQ <= stb.shift;
      fastQ     <= nextFast;
      cntQ      <= '0;
      slowQ     <= ~nextFast;
    end else begin
      cntQ  <= cntInc;
      slowQ <= (cntInc < halfCnt);
    end
  end

  // gate for undivided mode changes only while the master clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= runQ & fastQ;
  end

  assign sdClk   = fastQ ? (clk & gateQ) : slowQ;
  assign sdClkEn = runQ & (fastQ | (cntQ == '0));
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter bit HAS_DIV1024 = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             busIdle,
  output logic             sdClkEn,
  output logic             sdClk
);
  ctrl_stb_t          stb;
  logic               dpRun, dpSlow, dpFast, dpBoundary;
  logic [SHIFT_W-1:0] dpShift;

  sdclk_div_ctrl #(.HAS_DIV1024(HAS_DIV1024)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .busIdle   (busIdle),
    .stb       (stb)
  );

  sdclk_div_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sdClk     (sdClk),
    .sdClkEn   (sdClkEn),
    .runQ      (dpRun),
    .slowQ     (dpSlow),
    .fastQ     (dpFast),
    .boundary  (dpBoundary),
    .curShiftQ (dpShift)
  );
endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk
  import sdclk_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               runQ,
  input logic               slowLvl,
  input logic               fastSel,
  input logic               boundary,
  input logic               wantRun,
  input logic               sdClkEn,
  input logic [SHIFT_W-1:0] curShift
);
  localparam int HW = CNT_W + 1;

  logic [HW-1:0]      hiLen, hiExp;
  logic [SHIFT_W-1:0] hiShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiLen   <= '0;
      hiShift <= SH_HALF;
    end else begin
      hiLen <= slowLvl ? hiLen + HW'(1) : '0;
      if (slowLvl && hiLen == '0) hiShift <= curShift;
    end
  end

  assign hiExp = HW'(1) << (hiShift - SH_HALF);

  assert_strobe_in_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sdClkEn && !fastSel) |-> slowLvl);

  assert_full_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(slowLvl) |-> (hiLen == hiExp));

  assert_start_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> sdClkEn);

  assert_hold_ratio_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(runQ) && runQ && !$past(boundary)) |-> $stable(curShift));

  assert_mode_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    fastSel |-> !slowLvl);

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wantRun) && !$past(slowLvl) && !$past(fastSel)) |-> !slowLvl);
endmodule

bind sdclk_divider sdclk_divider_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .runQ     (dpRun),
  .slowLvl  (dpSlow),
  .fastSel  (dpFast),
  .boundary (dpBoundary),
  .wantRun  (stb.wantRun),
  .sdClkEn  (sdClkEn),
  .curShift (dpShift)
);

// File: tb/tb_sdclk_divider.sv
`timescale 1ns/100ps
module tb_sdclk_divider;
  localparam logic [31:0] EN    = 32'h0000_0100;
  localparam logic [31:0] IDLE  = 32'h0000_0200;
  localparam logic [31:0] UNDIV = 32'h0000_0400;
  localparam logic [31:0] SLOW  = 32'h0001_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic wrEn = 1'b0, wr2En = 1'b0;
  logic [31:0] wrData = '0, wr2Data = '0;
  logic busIdle = 1'b0;
  logic sdClk, sdClkEn, sdClkB, sdClkEnB;

  sdclk_divider #(.HAS_DIV1024(1'b1)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(wrEn), .cfgWrData(wrData),
    .busIdle(busIdle), .sdClkEn(sdClkEn), .sdClk(sdClk));

  sdclk_divider #(.HAS_DIV1024(1'b0)) dut512 (
    .clk(clk), .rstN(rstN), .cfgWrEn(wr2En), .cfgWrData(wr2Data),
    .busIdle(1'b0), .sdClkEn(sdClkEnB), .sdClk(sdClkB));

  typedef struct { int width; string req; } exp_t;
  exp_t expQ[$];

  int checks = 0, fails = 0, popCount = 0, cyc = 0;
  int lastPeriod = 0, prevEn = 0, hiRun = 0;
  bit seenEn = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input int w, input string req);
    exp_t e;
    e.width = w;
    e.req   = req;
    expQ.push_back(e);
  endtask

  // monitor: samples mid-cycle, compares each finished high phase
  always begin
    exp_t e;
    @(negedge clk);
    #1;
    cyc++;
    if (sdClkEn === 1'b1) begin
      if (seenEn) lastPeriod = cyc - prevEn;
      prevEn = cyc;
      seenEn = 1'b1;
    end
    if (sdClk === 1'b1) hiRun++;
    else if (hiRun > 0) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected high phase width", hiRun, 0);
      end else begin
        e = expQ.pop_front();
        check(hiRun == e.width, e.req, "high phase width", hiRun, e.width);
      end
      popCount++;
      hiRun = 0;
    end
  end

  task automatic writeReg(input logic [31:0] d);
    wrData = d;
    wrEn   = 1'b1;
    @(posedge clk);
    #1;
    wrEn   = 1'b0;
  endtask

  task automatic waitPulseHigh(input int target);
    do begin
      @(negedge clk);
      #1.5;
    end while (!(popCount == target && sdClk === 1'b1));
  endtask

  task automatic waitPops(input int target);
    do begin
      @(negedge clk);
      #1.5;
    end while (popCount < target);
  endtask

  task automatic quietCheck(input int n, input string req);
    int hi;
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      #1.5;
      if (sdClk !== 1'b0 || sdClkEn !== 1'b0) hi++;
    end
    check(hi == 0, req, "activity while stopped", hi, 0);
  endtask

  task automatic runRatio(input logic [31:0] bits, input int n, input string req,
                          input bit chkStart);
    int base;
    writeReg(bits);
    base = popCount;
    pushExp(n / 2, req);
    pushExp(n / 2, req);
    writeReg(bits | EN);
    if (chkStart) begin
      @(negedge clk);
      #1.5;
      check(sdClk === 1'b0, "R6", "clock one edge after accept", int'(sdClk), 0);
      @(negedge clk);
      #1.5;
      check(sdClk === 1'b1 && sdClkEn === 1'b1, "R6", "first high with strobe",
            int'({sdClk, sdClkEn}), 3);
    end
    waitPulseHigh(base + 1);
    writeReg(bits);
    waitPops(base + 2);
    quietCheck(2 * n + 6, "R7");
    check(popCount == base + 2, req, "pulse count", popCount - base, 2);
    check(lastPeriod == n, req, "strobe period", lastPeriod, n);
  endtask

  task automatic fastCheck(input logic [31:0] bits, input string req);
    int bad;
    writeReg(bits | EN);
    repeat (3) @(posedge clk);
    bad = 0;
    repeat (6) begin
      @(posedge clk);
      #1;
      if (!(sdClk === 1'b1 && sdClkEn === 1'b1)) bad++;
      @(negedge clk);
      #1;
      if (sdClk !== 1'b0) bad++;
    end
    check(bad == 0, req, "undivided clock follows master", bad, 0);
    writeReg(bits);
    repeat (3) @(posedge clk);
    bad = 0;
    repeat (6) begin
      @(posedge clk);
      #1;
      if (sdClk !== 1'b0) bad++;
    end
    check(bad == 0, "R7", "undivided clock stopped", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R6", "watchdog expired cycles", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int base, hi, lo;
    repeat (4) @(posedge clk);
    #1;
    check(sdClk === 1'b0 && sdClkEn === 1'b0, "R1", "outputs in reset",
          int'({sdClk, sdClkEn}), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    #1.5;
    check(sdClk === 1'b0 && sdClkEn === 1'b0, "R1", "outputs after reset",
          int'({sdClk, sdClkEn}), 0);

    // R2: divide by 2 and every one-hot ratio bit
    runRatio(32'h0, 2, "R2", 1'b0);
    for (int i = 0; i < 8; i++) runRatio(32'h1 << i, 4 << i, "R2", i == 1);

    // R4: slowest ratio with capability; R5: lowest bit wins
    runRatio(SLOW, 1024, "R4", 1'b0);
    runRatio(32'h28, 32, "R5", 1'b0);
    runRatio(SLOW | 32'h80, 512, "R5", 1'b1);

    // R3: undivided clock, also with other ratio bits set
    fastCheck(UNDIV, "R3");
    fastCheck(UNDIV | 32'h08 | SLOW, "R3");

    // R9: ratio change while running waits for the boundary
    writeReg(32'h02);
    base = popCount;
    pushExp(4, "R9");
    writeReg(32'h02 | EN);
    waitPulseHigh(base);
    writeReg(32'h01 | EN);
    pushExp(2, "R9");
    pushExp(2, "R9");
    waitPulseHigh(base + 1);
    check(lastPeriod == 8, "R9", "old period completes", lastPeriod, 8);
    waitPulseHigh(base + 2);
    writeReg(32'h01);
    waitPops(base + 3);
    check(lastPeriod == 4, "R9", "new period after boundary", lastPeriod, 4);
    quietCheck(12, "R7");

    // R8: idle stop, restart, and no effect when the stop bit is clear
    busIdle = 1'b0;
    base = popCount;
    pushExp(4, "R8");
    pushExp(4, "R8");
    writeReg(32'h02 | EN | IDLE);
    waitPulseHigh(base + 1);
    busIdle = 1'b1;
    waitPops(base + 2);
    quietCheck(30, "R8");
    check(popCount == base + 2, "R8", "pulses before idle stop", popCount - base, 2);
    pushExp(4, "R8");
    pushExp(4, "R8");
    busIdle = 1'b0;
    waitPulseHigh(base + 3);
    busIdle = 1'b1;
    waitPops(base + 4);
    quietCheck(30, "R8");
    pushExp(4, "R8");
    pushExp(4, "R8");
    writeReg(32'h02 | EN);
    waitPulseHigh(base + 5);
    writeReg(32'h02);
    waitPops(base + 6);
    quietCheck(20, "R7");
    check(popCount == base + 6, "R8", "idle ignored when stop bit clear",
          popCount - base, 6);
    busIdle = 1'b0;

    // R4: without the capability the slowest bit gives 512
    wr2Data = SLOW | EN;
    wr2En   = 1'b1;
    @(posedge clk);
    #1;
    wr2En = 1'b0;
    do begin @(negedge clk); #1.5; end while (sdClkB !== 1'b1);
    hi = 0;
    while (sdClkB === 1'b1) begin hi++; @(negedge clk); #1.5; end
    lo = 0;
    while (sdClkB === 1'b0) begin lo++; @(negedge clk); #1.5; end
    check(hi == 256, "R4", "high width without capability", hi, 256);
    check(lo == 256, "R4", "low width without capability", lo, 256);
    wr2Data = SLOW;
    wr2En   = 1'b1;
    @(posedge clk);
    #1;
    wr2En = 1'b0;

    repeat (4) @(posedge clk);
    check(expQ.size() == 0, "R2", "expected phases left over", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule